// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a clocked 64-bit static memory with a 16-bit word address. It captures address, control and write data on every rising clock edge. An address load starts an access. After that, a two-bit internal counter supplies the lowest address bits, so up to four neighbouring words can be reached without a new address. Writes happen on the capturing edge. Reads return data one clock later. A data-drive flag, gated by an asynchronous output enable, stands in for a tri-state data bus.

A new address is taken when the active-low address strobe and the active-low primary enable are both low in the same cycle. In that cycle the two secondary enables are sampled, and the memory stays selected only if both agree. Writes come in two forms. A global write covers the whole word. Otherwise a gated byte-write enable applies eight per-byte strobes. Storage holds 2^STORE_AW words (256 by default), and the address bits above that range select nothing.

Top module: `burst_sram`

## Requirements
- R1: After reset, dout_drive stays low until a selected read has been registered.
- R2: When adr_strobe_n and ce_n are both low at an edge, the external address is loaded, the counter takes addr[1:0], and the selection becomes (ce_lo_n low AND ce_hi high). When ce_n is high, adr_strobe_n has no effect, and the access continues from the current burst address.
- R3: In a cycle with no load, burst_adv high increments the two low address bits modulo 4 (linear order with wrap), and the upper bits are kept. With burst_adv low, the same word is accessed again.
- R4: With gw_n high and bwe_n low, each low bit k of bw_n (k = 0..7) writes din[8k+7:8k] into byte k of the addressed word, and the other bytes are kept. When bwe_n is high, bw_n has no effect and the cycle is a read.
- R5: With gw_n low, all 64 bits are written, whatever bwe_n and bw_n are.
- R6: In a selected cycle with no write, dout shows the word at that cycle's address after the next rising edge, and dout_drive rises with it.
- R7: While the latched selection is false, no write changes storage and dout_drive stays low after the following edge.
- R8: oe_n high forces dout_drive low at once, without waiting for a clock edge.
- R9: In any cycle where a write is requested (gw_n low, or bwe_n low with any bw_n bit low), dout_drive is low in that same cycle.
- R10: Storage is indexed by the low STORE_AW address bits. Addresses that differ only above them reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | External word address |
| adr_strobe_n | input | 1 | Active-low address load request |
| burst_adv | input | 1 | Steps the burst counter when high |
| ce_n | input | 1 | Active-low primary enable, qualifies the load |
| ce_lo_n | input | 1 | Active-low secondary enable, sampled on load |
| ce_hi | input | 1 | Active-high secondary enable, sampled on load |
| gw_n | input | 1 | Active-low full-word write |
| bwe_n | input | 1 | Active-low gate for the byte strobes |
| bw_n | input | LANES | Active-low byte strobes, bit k for byte k |
| oe_n | input | 1 | Active-low asynchronous output enable |
| din | input | LANES*BYTE_W | Write data |
| dout | output | LANES*BYTE_W | Registered read data |
| dout_drive | output | 1 | High when dout would drive the bus |

## Verification
The clocked assertions take for granted that every control and address input has a defined level at each rising edge after reset. They also assume that the inputs do not change in the edge's neighbourhood. The counter and base-hold properties compare the registered state against the past values of the strobe, the advance input and the address. The stimulus meets these assumptions by changing every input only at the falling edge, from one task. Random patterns draw from fully defined values, and each edge's expectation is taken from the levels that were held across that edge.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
  parameter int unsigned SRAM_BYTE_W = 8;
  parameter int unsigned SRAM_CNT_W  = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/burst_sram_addr.sv
`timescale 1ns/1ps
module burst_sram_addr #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned STORE_AW = 8,
  parameter int unsigned CNT_W    = burst_sram_pkg::SRAM_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                adr_strobe_n,
  input  logic                burst_adv,
  input  logic                ce_n,
  input  logic                ce_lo_n,
  input  logic                ce_hi,
  output logic [STORE_AW-1:0] store_idx,
  output logic                eff_sel
);
  localparam int unsigned HI_W = ADDR_W - CNT_W;

  logic              ld;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, cnt_next;
  logic              sel_q;
  logic [ADDR_W-1:0] eff_addr;

  // primary enable qualifies the strobe
  assign ld = ~adr_strobe_n & ~ce_n;

  always_comb begin
    if (ld) begin
      cnt_next = addr[CNT_W-1:0];
      eff_addr = addr;
      eff_sel  = ~ce_lo_n & ce_hi;
    end else begin
      cnt_next = burst_adv ? cnt_q + 1'b1 : cnt_q;
      eff_addr = {base_q[ADDR_W-1:CNT_W], cnt_next};
      eff_sel  = sel_q;
    end
  end

  assign store_idx = eff_addr[STORE_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (ld) base_q <= addr;
      cnt_q <= cnt_next;
      sel_q <= eff_sel;
    end
  end

  assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(addr[CNT_W-1:0]));
  assert_base_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(base_q[ADDR_W-1:CNT_W]) && HI_W > 0);
  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && burst_adv) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !burst_adv) |=> $stable(cnt_q));
endmodule

// File: rtl/burst_sram_wdec.sv
`timescale 1ns/1ps
module burst_sram_wdec #(
  parameter int unsigned LANES = 8
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             sel,
  output logic [LANES-1:0] lane_we,
  output logic             wr_req
);
  logic [LANES-1:0] mask;

  always_comb begin
    if (!gw_n)       mask = '1;
    else if (!bwe_n) mask = ~bw_n;
    else             mask = '0;
  end

  assign wr_req  = |mask;
  assign lane_we = sel ? mask : '0;
endmodule

// File: rtl/burst_sram_lane.sv
`timescale 1ns/1ps
module burst_sram_lane #(
  parameter int unsigned AW = 8,
  parameter int unsigned W  = burst_sram_pkg::SRAM_BYTE_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= din;
    if (re) dout <= cells[addr];
  end
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned STORE_AW = 8,
  parameter int unsigned LANES    = 8,
  parameter int unsigned BYTE_W   = SRAM_BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      adr_strobe_n,
  input  logic                      burst_adv,
  input  logic                      ce_n,
  input  logic                      ce_lo_n,
  input  logic                      ce_hi,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      oe_n,
  input  logic [LANES*BYTE_W-1:0]   din,
  output logic [LANES*BYTE_W-1:0]   dout,
  output logic                      dout_drive
);
  logic [STORE_AW-1:0] store_idx;
  logic                eff_sel;
  logic [LANES-1:0]    lane_we;
  logic                wr_req;
  logic                rd_en;
  logic                rd_vld_q;
  sram_op_e            op;

  burst_sram_addr #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adr_strobe_n(adr_strobe_n),
    .burst_adv(burst_adv), .ce_n(ce_n), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi),
    .store_idx(store_idx), .eff_sel(eff_sel)
  );

  burst_sram_wdec #(.LANES(LANES)) u_wdec (
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .sel(eff_sel),
    .lane_we(lane_we), .wr_req(wr_req)
  );

  always_comb begin
    if (!eff_sel)    op = OP_IDLE;
    else if (wr_req) op = OP_WRITE;
    else             op = OP_READ;
  end
  assign rd_en = (op == OP_READ);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    burst_sram_lane #(.AW(STORE_AW), .W(BYTE_W)) u_lane (
      .clk(clk), .we(lane_we[g]), .re(rd_en), .addr(store_idx),
      .din(din[g*BYTE_W +: BYTE_W]), .dout(dout[g*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= rd_en;
  end

  // output enable and write request gate the drive flag without a clock
  assign dout_drive = rd_vld_q & ~oe_n & ~wr_req;

  assert_write_blocks_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !rd_vld_q);
  assert_desel_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_sel |=> !rd_vld_q);
  assert_desel_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |-> eff_sel);
endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        adr_strobe_n = 1'b1, burst_adv = 1'b0, ce_n = 1'b1;
  logic        ce_lo_n = 1'b0, ce_hi = 1'b1;
  logic        gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [7:0]  bw_n = 8'hFF;
  logic [63:0] din = '0;
  logic [63:0] dout;
  logic        dout_drive;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [63:0] model [DEPTH];
  logic [15:0] m_base = '0;
  logic [1:0]  m_cnt = '0;
  logic        m_sel = 1'b0, m_vld = 1'b0;
  logic [63:0] m_dout = '0;

  always #10 clk = ~clk;

  burst_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adr_strobe_n(adr_strobe_n),
    .burst_adv(burst_adv), .ce_n(ce_n), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_drive(dout_drive)
  );

  function automatic logic [63:0] pat(input int i);
    return {16'(i), 16'hA5C3 ^ 16'(i * 7), ~16'(i), 16'h1357 + 16'(i)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic wr_now();
    return !gw_n || (!bwe_n && bw_n != 8'hFF);
  endfunction

  task automatic check_out();
    logic exp_drv;
    string tag;
    exp_drv = m_vld && !oe_n && !wr_now();
    if (wr_now())   tag = "R9 drive";
    else if (oe_n)  tag = "R8 drive";
    else if (!m_vld) tag = "R7 drive";
    else            tag = "R6 drive";
    chk(tag, 64'(dout_drive), 64'(exp_drv));
    if (exp_drv) chk("R6 data", dout, m_dout);
  endtask

  // expected effect of one rising edge, from the requirements
  task automatic model_edge();
    logic [15:0] ea;
    logic [7:0]  mask;
    int          idx;
    if (!adr_strobe_n && !ce_n) begin
      m_base = addr; m_cnt = addr[1:0]; m_sel = !ce_lo_n && ce_hi; ea = addr;
    end else begin
      if (burst_adv) m_cnt = m_cnt + 2'd1;
      ea = {m_base[15:2], m_cnt};
    end
    mask = !gw_n ? 8'hFF : (!bwe_n ? ~bw_n : 8'h00);
    idx = int'(ea) % DEPTH;
    if (m_sel && mask != 0) begin
      for (int k = 0; k < 8; k++)
        if (mask[k]) model[idx][k*8 +: 8] = din[k*8 +: 8];
      m_vld = 1'b0;
    end else if (m_sel) begin
      m_vld = 1'b1; m_dout = model[idx];
    end else m_vld = 1'b0;
  endtask

  task automatic step();
    #1 check_out();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic drive(input logic s_n, input logic c_n, input logic lo_n, input logic hi,
                       input logic [15:0] a, input logic adv, input logic g_n,
                       input logic be_n, input logic [7:0] b_n, input logic [63:0] d);
    adr_strobe_n = s_n; ce_n = c_n; ce_lo_n = lo_n; ce_hi = hi; addr = a;
    burst_adv = adv; gw_n = g_n; bwe_n = be_n; bw_n = b_n; din = d;
    step();
  endtask

  task automatic rd_load(input logic [15:0] a);
    drive(0, 0, 0, 1, a, 0, 1, 1, 8'hFF, '0);
  endtask

  task automatic cont(input logic adv);
    drive(1, 1, 0, 1, 16'h0, adv, 1, 1, 8'hFF, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] expw;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset drive", 64'(dout_drive), 64'd0);
    @(negedge clk);

    // fill with global write, byte gate left high (R5)
    for (int i = 0; i < DEPTH; i++) drive(0, 0, 0, 1, 16'(i), 0, 0, 1, 8'hFF, pat(i));

    // R5: global write overrides a partial byte strobe pattern
    drive(0, 0, 0, 1, 16'h0005, 0, 0, 0, 8'hF0, 64'h0123_4567_89AB_CDEF);
    rd_load(16'h0005);
    chk("R5 global write", dout, 64'h0123_4567_89AB_CDEF);

    // R4: only bytes 0 and 2 written
    drive(0, 0, 0, 1, 16'h0009, 0, 1, 0, 8'b1111_1010, 64'hFFEE_DDCC_BBAA_9988);
    rd_load(16'h0009);
    expw = pat(9); expw[7:0] = 8'h88; expw[23:16] = 8'hAA;
    chk("R4 partial bytes", dout, expw);
    // R4: strobes without the byte gate have no effect
    drive(0, 0, 0, 1, 16'h000A, 0, 1, 1, 8'h00, 64'hDEAD_DEAD_DEAD_DEAD);
    rd_load(16'h000A);
    chk("R4 strobes ungated", dout, pat(10));

    // R3: burst from low bits 2 wraps to 3,0,1 then waits
    rd_load(16'h0102);
    chk("R3 burst first", dout, pat(2));
    cont(1); chk("R3 burst second", dout, pat(3));
    cont(1); chk("R3 burst wrap", dout, pat(0));
    cont(1); chk("R3 burst fourth", dout, pat(1));
    cont(0); chk("R3 wait cycle", dout, pat(1));

    // R2: strobe while primary enable is high is ignored
    drive(0, 1, 0, 1, 16'h0040, 0, 1, 1, 8'hFF, '0);
    chk("R2 strobe ignored", dout, pat(1));

    // R7: deselect by each secondary enable; writes must not land
    drive(0, 0, 1, 1, 16'h0020, 0, 0, 1, 8'hFF, '0);
    drive(1, 1, 0, 1, 16'h0, 0, 0, 1, 8'hFF, '0);
    drive(0, 0, 0, 0, 16'h0020, 0, 0, 1, 8'hFF, '0);
    cont(0);
    rd_load(16'h0020);
    chk("R7 no write while deselected", dout, pat(32));

    // R8: output enable acts between edges
    oe_n = 1'b1; #1 chk("R8 oe high", 64'(dout_drive), 64'd0);
    oe_n = 1'b0; #1 chk("R8 oe low", 64'(dout_drive), 64'd1);

    // R9: byte write request drops drive within the cycle
    bwe_n = 1'b0; bw_n = 8'hFE; #1 chk("R9 write cycle drive", 64'(dout_drive), 64'd0);
    bwe_n = 1'b1; bw_n = 8'hFF;

    // R10: upper address bits alias
    drive(0, 0, 0, 1, 16'h1234, 0, 0, 1, 8'hFF, 64'h5A5A_0F0F_C3C3_9696);
    rd_load(16'hAB34);
    chk("R10 alias", dout, 64'h5A5A_0F0F_C3C3_9696);

    // constrained random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      oe_n = ($urandom % 8) == 0;
      drive(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
            ($urandom % 6) != 0, 16'($urandom), 1'($urandom), ($urandom % 6) != 0,
            1'($urandom), 8'($urandom), {$urandom, $urandom});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule